// File: doc/BRIEF.md
# Transactional Node Data Cache with Commit Snooping

This block is the data cache of one processor node in a multiprocessor where work is grouped into transactions and the global order of memory effects is the order in which transactions commit. While a transaction runs, every store stays inside this cache and is invisible to the rest of the system. Every line the transaction loads is marked as read. Coherence uses no ownership states. Instead, the block watches the commit packets that other nodes broadcast. A matching clean line is dropped if the packet carries only an address, and refreshed if the packet carries data. If the packet touches a line the running transaction has read, the block reports a violation so the processor can roll back and restart.

When the processor commits, the block walks every set in index order and streams out each speculatively written line with its address and data. It then turns all lines into clean, valid copies. An abort, or a violation, throws away every speculatively written line and keeps the clean ones. The cache is direct mapped with one data word per line. It never writes a speculative line back to make room for another address. A request that would need to evict such a line stalls with an overflow flag.

Top module: `tcc_node_cache`

## Requirements
- R1: After reset no line is valid, no transaction is open, and all outputs are low. A processor request made outside an open transaction (before `txn_begin`, after a violation, an abort or a commit) is never acknowledged.
- R2: A store inside a transaction is acknowledged in the same cycle. A later load to the same address returns the most recent stored value, so a node may overwrite its own speculative data freely. `cm_valid` stays low until the node commits.
- R3: An address splits into index (its low log2(SETS) bits) and tag (the remaining bits). A request whose index holds a valid line with another tag, where that line has its read or modified mark set, raises `cpu_ovf`. Such a request gets no acknowledge and no fill request, and the resident line is kept.
- R4: A load miss raises `fill_req` with `fill_addr` equal to the load address and no acknowledge. The word presented with `fill_valid` is installed as a clean line marked read. In the next cycle the load is acknowledged with that word.
- R5: An incoming commit packet that carries only an address invalidates a matching clean line, so the next load to that address misses.
- R6: An incoming commit packet that carries data overwrites a matching clean line, which stays valid. It causes no violation when the line has not been read in the running transaction.
- R7: An incoming commit address that matches a line read in the open transaction pulses `txn_violate` high for exactly one cycle, starting the cycle after the packet. The transaction closes, every modified line is invalidated, and clean lines are kept.
- R8: An incoming commit packet that matches a line this node has modified but not read leaves that line and its data unchanged, and raises no violation.
- R9: A commit lasts SETS cycles after the request. The cache visits indexes 0 to SETS-1 in order, one per cycle. `cm_valid` is high exactly in the cycles whose line is modified, with `cm_addr` = {tag, index} and `cm_data` = the line data. `cm_done` is high in the final cycle. Afterwards the lines are clean and valid, and they hit without a fill.
- R10: `txn_abort` closes the transaction with no violation pulse. It invalidates modified lines and keeps clean lines.
- R11: An incoming commit packet whose tag differs from the resident line at its index has no effect on that line and raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ack` on a load |
| cpu_ovf | output | 1 | Request stalled: it would evict a speculative line |
| fill_req | output | 1 | Load miss needs a word from the next level |
| fill_addr | output | ADDR_W | Address of the word needed |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | DATA_W | Fill word |
| txn_begin | input | 1 | Open a transaction |
| txn_commit | input | 1 | Commit the open transaction |
| txn_abort | input | 1 | Abandon the open transaction |
| txn_violate | output | 1 | One-cycle pulse: the running transaction read stale data |
| snp_valid | input | 1 | Incoming commit packet entry present |
| snp_addr | input | ADDR_W | Address in the incoming packet |
| snp_has_data | input | 1 | Packet entry carries data |
| snp_data | input | DATA_W | Data of the packet entry |
| cm_valid | output | 1 | Outgoing commit entry present |
| cm_addr | output | ADDR_W | Address of the outgoing entry |
| cm_data | output | DATA_W | Data of the outgoing entry |
| cm_done | output | 1 | Last cycle of this node's commit |

## Verification
Load and store sequences are applied inside one transaction. They cover hits, overwrites of already speculative data and requests that collide with a speculative line, which separates plain forwarding of stores from the overflow stall. Incoming commit packets are sent in four forms: address only on a clean line, with data on a clean line, on a modified but unread line, and on a line of another tag. Each form produces a different outcome, so a swapped snoop action or a missing tag compare is observable through later loads. A snoop on a read line, an abort and two commits (one with modified lines and one with none) then show which lines survive each way of closing a transaction and when the streamed entries appear.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [1:0] {
    TS_IDLE   = 2'd0,
    TS_ACTIVE = 2'd1,
    TS_COMMIT = 2'd2
  } txn_state_e;

  typedef enum logic [1:0] {
    SN_NONE    = 2'd0,
    SN_DROP    = 2'd1,
    SN_REFRESH = 2'd2,
    SN_KEEP    = 2'd3
  } snoop_act_e;

  // What an incoming commit entry does to a line it matches.
  function automatic snoop_act_e snoop_action(input logic hit, input logic line_mod,
                                              input logic has_data);
    if (!hit)          return SN_NONE;
    else if (line_mod) return SN_KEEP;
    else if (has_data) return SN_REFRESH;
    else               return SN_DROP;
  endfunction

endpackage

// File: rtl/tcc_line_store.sv
module tcc_line_store
  import tcc_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor side
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_store,
  input  logic              cpu_mark_rd,
  input  logic              fill_install,
  input  logic [DATA_W-1:0] fill_data,
  output logic              cpu_valid,
  output logic [TAG_W-1:0]  cpu_tagq,
  output logic [DATA_W-1:0] cpu_dataq,
  output logic              cpu_rd,
  output logic              cpu_mod,
  // snoop side
  input  logic [IDX_W-1:0]  snp_idx,
  input  snoop_act_e        snp_act,
  input  logic [DATA_W-1:0] snp_data,
  output logic              snp_lvalid,
  output logic [TAG_W-1:0]  snp_ltag,
  output logic              snp_lrd,
  output logic              snp_lmod,
  // transaction end
  input  logic              flush_spec,
  input  logic              clear_spec,
  // commit scan
  input  logic [IDX_W-1:0]  scan_idx,
  output logic              scan_mod,
  output logic [TAG_W-1:0]  scan_tag,
  output logic [DATA_W-1:0] scan_data
);

  logic              l_valid [SETS];
  logic              l_mod   [SETS];
  logic              l_rd    [SETS];
  logic [TAG_W-1:0]  l_tag   [SETS];
  logic [DATA_W-1:0] l_data  [SETS];

  for (genvar i = 0; i < SETS; i++) begin : g_line
    logic cpu_sel;
    logic snp_sel;
    assign cpu_sel = (cpu_idx == IDX_W'(i));
    assign snp_sel = (snp_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        l_valid[i] <= 1'b0;
        l_mod[i]   <= 1'b0;
        l_rd[i]    <= 1'b0;
        l_tag[i]   <= '0;
        l_data[i]  <= '0;
      end else begin
        // processor traffic: store, fill, read mark
        if (cpu_sel && cpu_store) begin
          l_valid[i] <= 1'b1;
          l_tag[i]   <= cpu_tag;
          l_data[i]  <= cpu_wdata;
          l_mod[i]   <= 1'b1;
        end
        if (cpu_sel && fill_install) begin
          l_valid[i] <= 1'b1;
          l_tag[i]   <= cpu_tag;
          l_data[i]  <= fill_data;
          l_mod[i]   <= 1'b0;
          l_rd[i]    <= 1'b1;
        end
        if (cpu_sel && cpu_mark_rd) begin
          l_rd[i] <= 1'b1;
        end
        // commit broadcast from another node
        if (snp_sel && (snp_act == SN_DROP)) begin
          l_valid[i] <= 1'b0;
        end
        if (snp_sel && (snp_act == SN_REFRESH)) begin
          l_data[i] <= snp_data;
        end
        // end of transaction
        if (flush_spec) begin
          if (l_mod[i]) l_valid[i] <= 1'b0;
          l_mod[i] <= 1'b0;
          l_rd[i]  <= 1'b0;
        end else if (clear_spec) begin
          l_mod[i] <= 1'b0;
          l_rd[i]  <= 1'b0;
        end
      end
    end
  end

  assign cpu_valid  = l_valid[cpu_idx];
  assign cpu_tagq   = l_tag[cpu_idx];
  assign cpu_dataq  = l_data[cpu_idx];
  assign cpu_rd     = l_rd[cpu_idx];
  assign cpu_mod    = l_mod[cpu_idx];

  assign snp_lvalid = l_valid[snp_idx];
  assign snp_ltag   = l_tag[snp_idx];
  assign snp_lrd    = l_rd[snp_idx];
  assign snp_lmod   = l_mod[snp_idx];

  assign scan_mod   = l_mod[scan_idx];
  assign scan_tag   = l_tag[scan_idx];
  assign scan_data  = l_data[scan_idx];

endmodule

// File: rtl/tcc_snoop_match.sv
module tcc_snoop_match
  import tcc_pkg::*;
#(
  parameter int TAG_W = 13
) (
  input  logic             snp_valid,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic             snp_has_data,
  input  logic             track_reads,
  input  logic             line_valid,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             line_rd,
  input  logic             line_mod,
  output logic             snp_hit,
  output snoop_act_e       snp_act,
  output logic             snp_conflict
);

  assign snp_hit      = snp_valid && line_valid && (line_tag == snp_tag);
  assign snp_act      = snoop_action(snp_hit, line_mod, snp_has_data);
  assign snp_conflict = snp_hit && line_rd && track_reads;

endmodule

// File: rtl/tcc_commit_scan.sv
module tcc_commit_scan #(
  parameter int SETS  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  output logic [IDX_W-1:0] scan_idx,
  output logic             scan_last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS - 1);

  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign scan_idx  = cnt;
  assign scan_last = run && (cnt == LAST_IDX);

endmodule

// File: rtl/tcc_node_cache.sv
module tcc_node_cache
  import tcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ovf,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              txn_begin,
  input  logic              txn_commit,
  input  logic              txn_abort,
  output logic              txn_violate,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_has_data,
  input  logic [DATA_W-1:0] snp_data,
  output logic              cm_valid,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data,
  output logic              cm_done
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  txn_state_e state;

  // named internal events
  logic active, committing;
  logic lk_valid, lk_rd, lk_mod, lk_hit, lk_spec_victim;
  logic [TAG_W-1:0]  lk_tag;
  logic [DATA_W-1:0] lk_data;
  logic quiet;
  logic cpu_store, cpu_mark_rd, fill_install;
  logic sn_lvalid, sn_lrd, sn_lmod;
  logic [TAG_W-1:0] sn_ltag;
  logic snp_hit, snp_conflict;
  snoop_act_e snp_act;
  logic flush_spec, clear_spec, scan_start;
  logic [IDX_W-1:0] scan_idx;
  logic scan_last, scan_mod;
  logic [TAG_W-1:0]  scan_tag;
  logic [DATA_W-1:0] scan_data;
  logic violate_q;

  assign active     = (state == TS_ACTIVE);
  assign committing = (state == TS_COMMIT);

  // processor lookup
  assign lk_hit         = lk_valid && (lk_tag == addr_tag(cpu_addr));
  assign lk_spec_victim = lk_valid && !lk_hit && (lk_rd || lk_mod);
  assign quiet          = !snp_valid && !fill_valid && !txn_abort;

  assign cpu_ovf     = active && cpu_req && lk_spec_victim;
  assign cpu_ack     = active && cpu_req && quiet && !cpu_ovf && (cpu_we || lk_hit);
  assign cpu_rdata   = lk_data;
  assign cpu_store   = cpu_ack && cpu_we;
  assign cpu_mark_rd = cpu_ack && !cpu_we;

  assign fill_req     = active && cpu_req && !cpu_we && !lk_hit && !cpu_ovf;
  assign fill_addr    = cpu_addr;
  assign fill_install = fill_req && fill_valid && !snp_valid;

  // transaction control
  assign flush_spec = active && (snp_conflict || txn_abort);
  assign scan_start = active && txn_commit && !flush_spec;
  assign clear_spec = committing && scan_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TS_IDLE;
    end else begin
      unique case (state)
        TS_IDLE:   if (txn_begin) state <= TS_ACTIVE;
        TS_ACTIVE: begin
          if (flush_spec)      state <= TS_IDLE;
          else if (scan_start) state <= TS_COMMIT;
        end
        TS_COMMIT: if (scan_last) state <= TS_IDLE;
        default:   state <= TS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) violate_q <= 1'b0;
    else        violate_q <= snp_conflict;
  end
  assign txn_violate = violate_q;

  tcc_line_store #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_idx      (addr_index(cpu_addr)),
    .cpu_tag      (addr_tag(cpu_addr)),
    .cpu_wdata    (cpu_wdata),
    .cpu_store    (cpu_store),
    .cpu_mark_rd  (cpu_mark_rd),
    .fill_install (fill_install),
    .fill_data    (fill_data),
    .cpu_valid    (lk_valid),
    .cpu_tagq     (lk_tag),
    .cpu_dataq    (lk_data),
    .cpu_rd       (lk_rd),
    .cpu_mod      (lk_mod),
    .snp_idx      (addr_index(snp_addr)),
    .snp_act      (snp_act),
    .snp_data     (snp_data),
    .snp_lvalid   (sn_lvalid),
    .snp_ltag     (sn_ltag),
    .snp_lrd      (sn_lrd),
    .snp_lmod     (sn_lmod),
    .flush_spec   (flush_spec),
    .clear_spec   (clear_spec),
    .scan_idx     (scan_idx),
    .scan_mod     (scan_mod),
    .scan_tag     (scan_tag),
    .scan_data    (scan_data)
  );

  tcc_snoop_match #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid    (snp_valid),
    .snp_tag      (addr_tag(snp_addr)),
    .snp_has_data (snp_has_data),
    .track_reads  (active),
    .line_valid   (sn_lvalid),
    .line_tag     (sn_ltag),
    .line_rd      (sn_lrd),
    .line_mod     (sn_lmod),
    .snp_hit      (snp_hit),
    .snp_act      (snp_act),
    .snp_conflict (snp_conflict)
  );

  tcc_commit_scan #(.SETS(SETS), .IDX_W(IDX_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (scan_start),
    .run       (committing),
    .scan_idx  (scan_idx),
    .scan_last (scan_last)
  );

  assign cm_valid = committing && scan_mod;
  assign cm_addr  = join_addr(scan_tag, scan_idx);
  assign cm_data  = scan_data;
  assign cm_done  = clear_spec;

endmodule

// File: rtl/tcc_node_cache_chk.sv
module tcc_node_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_req,
  input logic cpu_we,
  input logic cpu_ack,
  input logic cpu_ovf,
  input logic fill_req,
  input logic active,
  input logic committing,
  input logic snp_valid,
  input logic snp_conflict,
  input logic txn_violate,
  input logic cm_valid,
  input logic cm_done
);

  // R1: acknowledges only while a transaction is open
  p_ack_in_txn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> active);

  // R2: nothing leaves the node before its own commit
  p_private_stores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> committing);

  // R3: a stalled request is neither acknowledged nor sent for a fill
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ovf |-> (!cpu_ack && !fill_req));

  // R4: fill requests come only from pending loads
  p_fill_from_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (cpu_req && !cpu_we));

  // R7: violation pulse follows a conflicting snoop
  p_violate_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txn_violate |-> $past(snp_conflict));

  // R7: a conflict closes the transaction
  p_violate_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_conflict |=> !active);

  // R7: a conflict needs an incoming packet
  p_conflict_needs_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_conflict |-> snp_valid);

  // R9: the final scan cycle ends the commit
  p_done_ends_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cm_done |=> !committing);

endmodule

bind tcc_node_cache tcc_node_cache_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_ack      (cpu_ack),
  .cpu_ovf      (cpu_ovf),
  .fill_req     (fill_req),
  .active       (active),
  .committing   (committing),
  .snp_valid    (snp_valid),
  .snp_conflict (snp_conflict),
  .txn_violate  (txn_violate),
  .cm_valid     (cm_valid),
  .cm_done      (cm_done)
);

// File: tb/sim_tcc_node_cache.sv
module sim_tcc_node_cache;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SETS   = 8;
  localparam int NVEC   = 8;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              exp_ack;
    logic              exp_ovf;
    logic [DATA_W-1:0] exp_data;
  } vec_t;

  // store / load traffic inside the first transaction (R2, R3)
  localparam vec_t VT [NVEC] = '{
    '{1'b1, 16'h0011, 32'h1111_0001, 1'b1, 1'b0, 32'h0},
    '{1'b1, 16'h0013, 32'h3333_0003, 1'b1, 1'b0, 32'h0},
    '{1'b0, 16'h0011, 32'h0,         1'b1, 1'b0, 32'h1111_0001},
    '{1'b0, 16'h0013, 32'h0,         1'b1, 1'b0, 32'h3333_0003},
    '{1'b1, 16'h0011, 32'h1111_0002, 1'b1, 1'b0, 32'h0},
    '{1'b0, 16'h0011, 32'h0,         1'b1, 1'b0, 32'h1111_0002},
    '{1'b1, 16'h0019, 32'hDEAD_0009, 1'b0, 1'b1, 32'h0},
    '{1'b0, 16'h001B, 32'h0,         1'b0, 1'b1, 32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ack, cpu_ovf, fill_req;
  logic [DATA_W-1:0] cpu_rdata;
  logic [ADDR_W-1:0] fill_addr;
  logic fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;
  logic txn_begin = 1'b0, txn_commit = 1'b0, txn_abort = 1'b0;
  logic txn_violate;
  logic snp_valid = 1'b0, snp_has_data = 1'b0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [DATA_W-1:0] snp_data = '0;
  logic cm_valid, cm_done;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  tcc_node_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .cpu_ovf(cpu_ovf),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data),
    .txn_begin(txn_begin), .txn_commit(txn_commit), .txn_abort(txn_abort),
    .txn_violate(txn_violate),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_has_data(snp_has_data), .snp_data(snp_data),
    .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data), .cm_done(cm_done)
  );

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request held for one cycle; sampled 1 time unit after the falling edge.
  task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        output logic ack, output logic [DATA_W-1:0] rd,
                        output logic ovf, output logic freq, output logic cmv);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    ack = cpu_ack; rd = cpu_rdata; ovf = cpu_ovf; freq = fill_req; cmv = cm_valid;
    @(posedge clk);
    #1 cpu_req = 1'b0;
  endtask

  task automatic pulse_ctl(input int which);
    @(negedge clk);
    if (which == 0) txn_begin = 1'b1;
    else if (which == 1) txn_commit = 1'b1;
    else txn_abort = 1'b1;
    @(posedge clk);
    #1 begin txn_begin = 1'b0; txn_commit = 1'b0; txn_abort = 1'b0; end
  endtask

  // Returns txn_violate in the cycle after the packet and in the cycle after that.
  task automatic snoop(input logic [ADDR_W-1:0] a, input logic hd, input logic [DATA_W-1:0] d,
                       output logic v1, output logic v2);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a; snp_has_data = hd; snp_data = d;
    @(posedge clk);
    #1 snp_valid = 1'b0;
    @(negedge clk); #1 v1 = txn_violate;
    @(negedge clk); #1 v2 = txn_violate;
  endtask

  task automatic load_hit(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                          input string req);
    logic ack, ovf, fr, cmv;
    logic [DATA_W-1:0] rd;
    access(1'b0, a, '0, ack, rd, ovf, fr, cmv);
    chk(ack === 1'b1 && fr === 1'b0, req, {30'd0, ack, fr}, 32'h2);
    chk(rd === exp, req, rd, exp);
  endtask

  task automatic load_miss(input logic [ADDR_W-1:0] a, input string req);
    logic ack, ovf, fr, cmv;
    logic [DATA_W-1:0] rd;
    access(1'b0, a, '0, ack, rd, ovf, fr, cmv);
    chk(ack === 1'b0 && fr === 1'b1, req, {30'd0, ack, fr}, 32'h1);
  endtask

  // Commit and check the SETS scan cycles. mod_mask marks indexes expected to stream.
  task automatic run_commit(input logic [SETS-1:0] mod_mask,
                            input logic [ADDR_W-1:0] exp_addr [SETS],
                            input logic [DATA_W-1:0] exp_data [SETS]);
    pulse_ctl(1);
    for (int k = 0; k < SETS; k++) begin
      @(negedge clk); #1;
      chk(cm_valid === mod_mask[k], "R9", {31'd0, cm_valid}, {31'd0, mod_mask[k]});
      if (mod_mask[k]) begin
        chk(cm_addr === exp_addr[k], "R9", {16'd0, cm_addr}, {16'd0, exp_addr[k]});
        chk(cm_data === exp_data[k], "R9", cm_data, exp_data[k]);
      end
      chk(cm_done === (k == SETS - 1), "R9", {31'd0, cm_done}, {31'd0, 1'(k == SETS - 1)});
    end
    @(negedge clk); #1;
    chk(cm_valid === 1'b0 && cm_done === 1'b0, "R9", {30'd0, cm_valid, cm_done}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic ack, ovf, fr, cmv, v1, v2;
    logic [DATA_W-1:0] rd;
    logic [ADDR_W-1:0] ea [SETS];
    logic [DATA_W-1:0] ed [SETS];

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state and no service outside a transaction
    @(negedge clk); #1;
    chk({cpu_ack, cpu_ovf, fill_req, txn_violate, cm_valid, cm_done} === 6'b0, "R1",
        {26'd0, cpu_ack, cpu_ovf, fill_req, txn_violate, cm_valid, cm_done}, 32'h0);
    access(1'b1, 16'h0011, 32'h0BAD_0BAD, ack, rd, ovf, fr, cmv);
    chk(ack === 1'b0, "R1", {31'd0, ack}, 32'h0);

    // R2 / R3: table of stores and loads in one transaction
    pulse_ctl(0);
    for (int i = 0; i < NVEC; i++) begin
      access(VT[i].we, VT[i].addr, VT[i].wdata, ack, rd, ovf, fr, cmv);
      chk(ack === VT[i].exp_ack, VT[i].exp_ovf ? "R3" : "R2", {31'd0, ack}, {31'd0, VT[i].exp_ack});
      chk(ovf === VT[i].exp_ovf, "R3", {31'd0, ovf}, {31'd0, VT[i].exp_ovf});
      chk(cmv === 1'b0, "R2", {31'd0, cmv}, 32'h0);
      if (VT[i].exp_ovf) chk(fr === 1'b0, "R3", {31'd0, fr}, 32'h0);
      if (!VT[i].we && VT[i].exp_ack) chk(rd === VT[i].exp_data, "R2", rd, VT[i].exp_data);
    end

    // R4: load miss, fill, then hit with the filled word
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0024;
    #1;
    chk(fill_req === 1'b1 && cpu_ack === 1'b0, "R4", {30'd0, fill_req, cpu_ack}, 32'h2);
    chk(fill_addr === 16'h0024, "R4", {16'd0, fill_addr}, 32'h24);
    @(negedge clk);
    fill_valid = 1'b1; fill_data = 32'hA5A5_0004;
    @(posedge clk);
    #1 fill_valid = 1'b0;
    @(negedge clk); #1;
    chk(cpu_ack === 1'b1 && cpu_rdata === 32'hA5A5_0004, "R4", cpu_rdata, 32'hA5A5_0004);
    @(posedge clk);
    #1 cpu_req = 1'b0;

    // R9: commit streams idx1 and idx3; R3: overflowed store did not replace idx1
    for (int k = 0; k < SETS; k++) begin ea[k] = '0; ed[k] = '0; end
    ea[1] = 16'h0011; ed[1] = 32'h1111_0002;
    ea[3] = 16'h0013; ed[3] = 32'h3333_0003;
    run_commit(8'b0000_1010, ea, ed);
    access(1'b0, 16'h0011, '0, ack, rd, ovf, fr, cmv);
    chk(ack === 1'b0, "R1", {31'd0, ack}, 32'h0);

    pulse_ctl(0);
    load_hit(16'h0011, 32'h1111_0002, "R9");

    // R6: data-carrying packet refreshes a clean unread line
    snoop(16'h0024, 1'b1, 32'h7777_0004, v1, v2);
    chk(v1 === 1'b0, "R6", {31'd0, v1}, 32'h0);
    load_hit(16'h0024, 32'h7777_0004, "R6");

    // R11: other tag at the same index has no effect
    snoop(16'h001C, 1'b0, '0, v1, v2);
    chk(v1 === 1'b0, "R11", {31'd0, v1}, 32'h0);
    load_hit(16'h0024, 32'h7777_0004, "R11");

    // R5: address-only packet drops a clean line
    snoop(16'h0013, 1'b0, '0, v1, v2);
    chk(v1 === 1'b0, "R5", {31'd0, v1}, 32'h0);
    load_miss(16'h0013, "R5");

    // R8: packet on a modified, unread line changes nothing
    access(1'b1, 16'h0015, 32'h5555_0005, ack, rd, ovf, fr, cmv);
    chk(ack === 1'b1, "R2", {31'd0, ack}, 32'h1);
    snoop(16'h0015, 1'b1, 32'hEEEE_EEEE, v1, v2);
    chk(v1 === 1'b0, "R8", {31'd0, v1}, 32'h0);
    load_hit(16'h0015, 32'h5555_0005, "R8");

    // R7: packet on a read line -> one-cycle violation, speculative lines dropped
    snoop(16'h0011, 1'b0, '0, v1, v2);
    chk(v1 === 1'b1, "R7", {31'd0, v1}, 32'h1);
    chk(v2 === 1'b0, "R7", {31'd0, v2}, 32'h0);
    access(1'b0, 16'h0024, '0, ack, rd, ovf, fr, cmv);
    chk(ack === 1'b0, "R7", {31'd0, ack}, 32'h0);
    pulse_ctl(0);
    load_miss(16'h0015, "R7");
    load_miss(16'h0011, "R7");
    load_hit(16'h0024, 32'h7777_0004, "R7");

    // R10: abort drops modified lines, keeps clean ones, no violation
    access(1'b1, 16'h0016, 32'h6666_0006, ack, rd, ovf, fr, cmv);
    chk(ack === 1'b1, "R2", {31'd0, ack}, 32'h1);
    pulse_ctl(2);
    @(negedge clk); #1;
    chk(txn_violate === 1'b0, "R10", {31'd0, txn_violate}, 32'h0);
    pulse_ctl(0);
    load_miss(16'h0016, "R10");
    load_hit(16'h0024, 32'h7777_0004, "R10");

    // R9: commit with nothing modified streams nothing but still ends
    run_commit(8'b0000_0000, ea, ed);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule